// File: doc/BRIEF.md
# Inverted-Sine Carrier PWM Modulator with Amplitude-Modulated Carrier

This block produces unipolar gate pulses for the two switch groups of a single-phase full-bridge inverter. A sinusoidal reference, scaled by a modulation-index word, is compared against a fast carrier. Each carrier cycle is an inverted sine arch: the carrier sits at its peak at both ends of the cycle and drops to zero in the middle. The peak of each arch is taken from the present magnitude of the full-scale reference sine. The carrier is therefore amplitude-modulated at the reference frequency. Compared with a triangle carrier, this widens pulses near the crest of the reference and raises the fundamental.

Both waveforms read from one read-only table that holds a quarter of a sine wave. The table has two read ports. Each waveform rebuilds its full shape with an address that sweeps up to the last entry and then back down. The reference also keeps a half-cycle flag that selects which switch group may fire. Two clock dividers set the reference sample rate and the carrier step rate.

With a 125 MHz clock, the defaults are a 10 kHz reference sample rate, 200 samples per reference period and 100 steps per carrier cycle. This gives a 50 Hz reference and a carrier of about 3 kHz.

Top module: `amisc_pwm`

## Requirements
- R1: While `rst_n` is low, `gate_p`, `gate_n` and `sample_stb` are 0. All dividers, table addresses, the half-cycle flag and the latched peak restart from zero.
- R2: When `en` is low at a clock edge, both gates and `sample_stb` are 0 after that edge. All counters and the latched peak keep their values, and the sequence resumes from where it stopped.
- R3: With `en` high, the reference advances one sample every `REF_DIV` cycles. `sample_stb` pulses for one cycle, one cycle after each advance. One reference period is 4*`ENTRIES` samples, so `sample_stb` pulses 4*`ENTRIES` times per period.
- R4: Table entry i (0 ≤ i < `ENTRIES`) equals round(2047·sin(π(i+1)/(2·`ENTRIES`))), so the last entry is 2047. The reference magnitude at sample k of a period uses the following entry:
  - entry k mod `ENTRIES` in quarters 0 and 2;
  - entry `ENTRIES`-1-(k mod `ENTRIES`) in quarters 1 and 3.
- R5: The carrier advances one step every `CAR_DIV` cycles, with 2*`ENTRIES` steps per arch. At step c, the table index is c for c < `ENTRIES` and 2*`ENTRIES`-1-c otherwise. The carrier value is floor(peak·(2047 − entry)/2048).
- R6: The peak is loaded only when the carrier wraps from its last step to step 0. It takes the unscaled reference magnitude of the sample current at that moment. It is 0 after reset.
- R7: The scaled reference is floor(magnitude·m/128), where m is `mod_idx` clamped to 128. 128 means a modulation index of 1.0, and every value above 128 acts as 128.
- R8: One cycle after an edge with `en` high in the positive half (reference samples 0 to 2*`ENTRIES`-1), `gate_p` is 1 exactly when the scaled reference ≥ carrier. `gate_n` is 0.
- R9: In the negative half, `gate_n` follows the same comparison and `gate_p` is 0. The two gates are never 1 in the same cycle.
- R10: When the reference period is a whole number of carrier cycles, the gate pattern repeats exactly once per reference period for a fixed `mod_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low freezes the sequence and silences the gates |
| mod_idx | input | MI_W | Modulation index, 128 = 1.0, clamped at 128 |
| gate_p | output | 1 | Positive-group gate |
| gate_n | output | 1 | Negative-group gate |
| sample_stb | output | 1 | One-cycle pulse per reference sample |

## Verification
The modulator runs at index values near 0.4, 0.8 and 1.0, and at zero. Comparing the number of gate-on cycles per period separates a working reference scaling from a missing or inverted one. A run at an index above 1.0 must give the same period pattern as 1.0, which shows whether the clamp works. Two equal-index periods are compared bit for bit to confirm the periodicity. A mid-period enable drop and a mid-run reset show whether the sequence freezes and restarts as required, where a design that keeps running or keeps stale state would differ.

// File: rtl/amisc_pkg.sv
package amisc_pkg;

  localparam int SAMPLE_W = 11;
  localparam int MI_W     = 8;

  typedef enum logic {
    SWEEP_UP = 1'b0,
    SWEEP_DN = 1'b1
  } sweep_e;

  // Rounded quarter-wave sample for entry idx of a table with the given entry count.
  function automatic int quarter_sample(input int idx, input int entries, input int width);
    real ang;
    ang = 3.141592653589793 * real'(idx + 1) / (2.0 * real'(entries));
    return $rtoi(real'((1 << width) - 1) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/amisc_quarter_rom.sv
module amisc_quarter_rom #(
  parameter int ENTRIES = 50,
  parameter int W       = amisc_pkg::SAMPLE_W,
  parameter int AW      = 6
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic [W-1:0]  data_a,
  output logic [W-1:0]  data_b
);

  logic [W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam int VAL = amisc_pkg::quarter_sample(i, ENTRIES, W);
    assign tbl[i] = W'(VAL);
  end

  always_comb begin
    data_a = '0;
    data_b = '0;
    if (int'(addr_a) < ENTRIES) data_a = tbl[addr_a];
    if (int'(addr_b) < ENTRIES) data_b = tbl[addr_b];
  end

endmodule

// File: rtl/amisc_step_div.sv
module amisc_step_div #(
  parameter int DIV = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic step
);

  if (DIV <= 1) begin : g_direct
    assign step = en;
  end else begin : g_count
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (en) begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign step = en && (cnt_q == LAST);
  end

endmodule

// File: rtl/amisc_bounce_addr.sv
module amisc_bounce_addr #(
  parameter int ENTRIES = 50,
  parameter int AW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  import amisc_pkg::*;

  localparam logic [AW-1:0] TOP = AW'(ENTRIES - 1);

  logic [AW-1:0] addr_q, addr_d;
  sweep_e        dir_q, dir_d;

  always_comb begin
    addr_d = addr_q;
    dir_d  = dir_q;
    if (step) begin
      if (dir_q == SWEEP_UP) begin
        if (addr_q == TOP) dir_d  = SWEEP_DN;
        else               addr_d = addr_q + 1'b1;
      end else begin
        if (addr_q == '0)  dir_d  = SWEEP_UP;
        else               addr_d = addr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= SWEEP_UP;
    end else begin
      addr_q <= addr_d;
      dir_q  <= dir_d;
    end
  end

  assign addr = addr_q;
  assign wrap = step && (dir_q == SWEEP_DN) && (addr_q == '0);

endmodule

// File: rtl/amisc_pwm.sv
module amisc_pwm #(
  parameter int REF_DIV  = 12500,
  parameter int CAR_DIV  = 417,
  parameter int ENTRIES  = 50,
  parameter int SAMPLE_W = amisc_pkg::SAMPLE_W,
  parameter int MI_W     = amisc_pkg::MI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [MI_W-1:0] mod_idx,
  output logic            gate_p,
  output logic            gate_n,
  output logic            sample_stb
);

  localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int MI_FRAC = MI_W - 1;
  localparam int RP_W    = SAMPLE_W + MI_W;
  localparam int CP_W    = 2 * SAMPLE_W;
  localparam logic [MI_W-1:0]     MI_ONE = MI_W'(1) << MI_FRAC;
  localparam logic [SAMPLE_W-1:0] FULL   = '1;

  logic                ref_step, car_step;
  logic [AW-1:0]       ref_addr, car_addr;
  logic                ref_wrap, car_wrap;
  logic [SAMPLE_W-1:0] ref_mag, car_sin;

  logic                neg_half_q, neg_half_d;
  logic [SAMPLE_W-1:0] peak_q, peak_d;
  logic                gate_p_d, gate_n_d, stb_d;

  logic [MI_W-1:0]     mi_eff;
  logic [RP_W-1:0]     ref_prod;
  logic [SAMPLE_W-1:0] ref_scaled;
  logic [CP_W-1:0]     car_prod;
  logic [SAMPLE_W-1:0] car_val;
  logic                hit;

  amisc_step_div #(.DIV(REF_DIV)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .en(en), .step(ref_step)
  );

  amisc_step_div #(.DIV(CAR_DIV)) u_car_div (
    .clk(clk), .rst_n(rst_n), .en(en), .step(car_step)
  );

  amisc_bounce_addr #(.ENTRIES(ENTRIES), .AW(AW)) u_ref_addr (
    .clk(clk), .rst_n(rst_n), .step(ref_step), .addr(ref_addr), .wrap(ref_wrap)
  );

  amisc_bounce_addr #(.ENTRIES(ENTRIES), .AW(AW)) u_car_addr (
    .clk(clk), .rst_n(rst_n), .step(car_step), .addr(car_addr), .wrap(car_wrap)
  );

  amisc_quarter_rom #(.ENTRIES(ENTRIES), .W(SAMPLE_W), .AW(AW)) u_rom (
    .addr_a(ref_addr), .addr_b(car_addr), .data_a(ref_mag), .data_b(car_sin)
  );

  // Reference scaling by the clamped modulation index
  always_comb begin
    mi_eff     = (mod_idx > MI_ONE) ? MI_ONE : mod_idx;
    ref_prod   = RP_W'(ref_mag) * RP_W'(mi_eff);
    ref_scaled = ref_prod[MI_FRAC +: SAMPLE_W];
  end

  // Inverted-sine carrier arch scaled by the latched peak
  always_comb begin
    car_prod = CP_W'(peak_q) * CP_W'(FULL - car_sin);
    car_val  = car_prod[SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    hit        = (ref_scaled >= car_val);
    neg_half_d = neg_half_q ^ ref_wrap;
    peak_d     = car_wrap ? ref_mag : peak_q;
    gate_p_d   = en && !neg_half_q && hit;
    gate_n_d   = en &&  neg_half_q && hit;
    stb_d      = ref_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_half_q <= 1'b0;
      peak_q     <= '0;
      gate_p     <= 1'b0;
      gate_n     <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      neg_half_q <= neg_half_d;
      peak_q     <= peak_d;
      gate_p     <= gate_p_d;
      gate_n     <= gate_n_d;
      sample_stb <= stb_d;
    end
  end

endmodule

// File: rtl/amisc_pwm_chk.sv
module amisc_pwm_chk #(
  parameter int SAMPLE_W = amisc_pkg::SAMPLE_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                gate_p,
  input logic                gate_n,
  input logic                sample_stb,
  input logic [SAMPLE_W-1:0] car_val,
  input logic [SAMPLE_W-1:0] peak_q,
  input logic                car_wrap,
  input logic                neg_half_q
);

  // R9
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_p && gate_n));

  // R2
  en_low_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_p && !gate_n));

  // R2
  en_low_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sample_stb);

  // R5
  car_le_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    car_val <= peak_q);

  // R6
  peak_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(peak_q) |-> $past(car_wrap));

  // R8
  pos_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_p |-> $past(!neg_half_q));

  // R9
  neg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_n |-> $past(neg_half_q));

endmodule

bind amisc_pwm amisc_pwm_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate_p(gate_p), .gate_n(gate_n),
  .sample_stb(sample_stb), .car_val(car_val), .peak_q(peak_q),
  .car_wrap(car_wrap), .neg_half_q(neg_half_q)
);

// File: tb/amisc_pwm_bench.sv
`timescale 1ns/1ps
module amisc_pwm_bench;

  localparam int QN     = 50;
  localparam int RDIV   = 8;
  localparam int CDIV   = 1;
  localparam int PER    = 4 * QN * RDIV;
  localparam int WDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] ma;
  logic       gate_p, gate_n, sample_stb;

  always #4 clk = ~clk;

  amisc_pwm #(.REF_DIV(RDIV), .CAR_DIV(CDIV), .ENTRIES(QN)) u_amisc_pwm (
    .clk(clk), .rst_n(rst_n), .en(en), .mod_idx(ma),
    .gate_p(gate_p), .gate_n(gate_n), .sample_stb(sample_stb)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  // behavioural model state
  int m_rdiv, m_k, m_cdiv, m_c, m_peak;
  int m_gp, m_gn, m_stb;

  logic [1:0] cap [2][PER];

  function automatic int tval(input int i);
    return $rtoi(2047.0 * $sin(3.141592653589793 * real'(i + 1) / (2.0 * real'(QN))) + 0.5);
  endfunction

  function automatic int ref_mag(input int k);   // R4
    int q, j;
    q = k / QN;
    j = k % QN;
    return (q % 2 == 0) ? tval(j) : tval(QN - 1 - j);
  endfunction

  function automatic int car_now(input int c, input int pk);   // R5
    int idx;
    idx = (c < QN) ? c : 2 * QN - 1 - c;
    return (pk * (2047 - tval(idx))) / 2048;
  endfunction

  function automatic int scaled(input int k, input int mi);    // R7
    int me;
    me = (mi > 128) ? 128 : mi;
    return (ref_mag(k) * me) / 128;
  endfunction

  task automatic model_reset();
    m_rdiv = 0; m_k = 0; m_cdiv = 0; m_c = 0; m_peak = 0;
    m_gp = 0; m_gn = 0; m_stb = 0;
  endtask

  task automatic model_edge();
    int hit, rt, ct, ok;
    if (!rst_n) begin
      model_reset();
      return;
    end
    hit   = (scaled(m_k, int'(ma)) >= car_now(m_c, m_peak)) ? 1 : 0;
    rt    = (m_rdiv == RDIV - 1) ? 1 : 0;
    ct    = (m_cdiv == CDIV - 1) ? 1 : 0;
    m_gp  = (en && m_k <  2 * QN && hit == 1) ? 1 : 0;
    m_gn  = (en && m_k >= 2 * QN && hit == 1) ? 1 : 0;
    m_stb = (en && rt == 1) ? 1 : 0;
    if (en) begin
      m_rdiv = (rt == 1) ? 0 : m_rdiv + 1;
      m_cdiv = (ct == 1) ? 0 : m_cdiv + 1;
      if (ct == 1) begin
        if (m_c == 2 * QN - 1) begin
          m_c    = 0;
          m_peak = ref_mag(m_k);   // R6 uses pre-edge sample
        end else begin
          m_c = m_c + 1;
        end
      end
      if (rt == 1) m_k = (m_k + 1) % (4 * QN);
    end
    ok = 0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    #1;
    model_edge();
    check(tag, {29'd0, gate_p, gate_n, sample_stb}, {29'd0, m_gp[0], m_gn[0], m_stb[0]});
    check("R9", int'(gate_p && gate_n), 0);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic run_cap(input int sel, input string tag, output int highs, output int stbs);
    highs = 0;
    stbs  = 0;
    for (int i = 0; i < PER; i++) begin
      cyc(tag);
      cap[sel][i] = {gate_p, gate_n};
      highs += int'(gate_p) + int'(gate_n);
      stbs  += int'(sample_stb);
    end
  endtask

  function automatic int cap_diff();
    int d;
    d = 0;
    for (int i = 0; i < PER; i++) if (cap[0][i] != cap[1][i]) d++;
    return d;
  endfunction

  initial begin
    int h_lo, h_hi, h_zero, s;
    rst_n = 1'b0;
    en    = 1'b0;
    ma    = 8'd0;
    model_reset();
    // R1: outputs quiet under reset
    run(4, "R1");
    check("R1", int'(gate_p) + int'(gate_n) + int'(sample_stb), 0);
    rst_n = 1'b1;
    en    = 1'b1;
    ma    = 8'd51;
    run(PER, "R8");
    run_cap(0, "R8", h_lo, s);
    check("R3", s, 4 * QN);
    ma = 8'd102;
    run(PER, "R5");
    ma = 8'd128;
    run_cap(1, "R9", h_hi, s);
    check("R3", s, 4 * QN);
    check("R7", int'(h_hi > h_lo), 1);
    run_cap(0, "R10", h_lo, s);
    check("R10", cap_diff(), 0);
    ma = 8'd200;
    run_cap(0, "R7", h_lo, s);
    check("R7", cap_diff(), 0);
    ma = 8'd0;
    run_cap(0, "R7", h_zero, s);
    check("R7", int'(h_zero < h_hi), 1);
    // R2: freeze mid-period
    ma = 8'd102;
    run(333, "R6");
    en = 1'b0;
    run(37, "R2");
    check("R2", int'(gate_p) + int'(gate_n) + int'(sample_stb), 0);
    en = 1'b1;
    run(PER, "R2");
    // R1: reset in the middle of a run
    rst_n = 1'b0;
    #1;
    check("R1", int'(gate_p) + int'(gate_n) + int'(sample_stb), 0);
    run(3, "R1");
    rst_n = 1'b1;
    run(PER, "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule